// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This unit sits next to a cache and catches sequential access streams. Each cache miss is offered to it as a block address. When the address equals the block at the front of its small queue and that block's data is present, the unit returns the data and reports a hit, so the cache does not need to go to memory. The front entry is then dropped, and the block one past the current tail is fetched to keep the queue full. Any other miss counts as a real miss. It discards the queue and starts a new stream that fetches the next four consecutive blocks after the missing one.

Memory traffic uses a request channel and an in-order response channel. Each request carries a small stream-generation tag. A response whose tag does not match the current stream is dropped, so data from an abandoned stream can never fill the new one. If the front entry has been requested but its data has not yet arrived, a matching lookup waits for the response and then completes as a hit.

The lookup channel (`miss_valid`/`miss_ready`), the result channel (`res_valid`/`res_ready`) and the request channel (`mreq_valid`/`mreq_ready`) all follow valid/ready rules. A transfer happens on a rising clock edge where both are high. Once valid is raised, the sender holds valid and its payload steady until the transfer happens. Only one lookup is in progress at a time: `miss_ready` stays low from acceptance until the result has been taken. The response channel has no back-pressure, and every response must be accepted in the cycle it is presented. Addresses count whole blocks and wrap modulo 2^ADDR_W. `DEPTH` must be a power of two.

Top module: `seq_stream_buf`

## Requirements
- R1: After synchronous active-high reset the queue is empty: `miss_ready`=1, `res_valid`=0, `mreq_valid`=0.
- R2: A lookup at block A that is not served from the buffer (empty buffer or no front match) returns `res_hit`=0. It is followed by requests for A+1, A+2, A+3, A+4 in that order, all carrying one new tag.
- R3: A lookup equal to the front block whose data is present returns `res_hit`=1 with the data the memory returned for that block.
- R4: Each front hit removes that entry and causes exactly one further request, for the block one past the previous tail (A+5 after the first hit).
- R5: A lookup equal to the front block whose data is still outstanding holds `res_valid` low until the response arrives, then returns `res_hit`=1 with that data.
- R6: Only the front is compared. A lookup matching a deeper entry is a miss and restarts the stream from that address.
- R7: After a restart, responses whose tag belongs to an earlier stream are discarded and never returned as hit data.
- R8: While `mreq_valid`=1 and `mreq_ready`=0, the request address and tag stay unchanged.
- R9: While `res_valid`=1 and `res_ready`=0, hit flag and data stay unchanged and `miss_ready` stays 0.
- R10: Block addresses wrap: a stream from 0xFFFF-1 fetches 0xFFFF, 0x0000, 0x0001, 0x0002 (16-bit default).
- R11: No more than DEPTH blocks are requested ahead of the front without responses. With no responses returning, a new stream issues exactly four requests and then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss lookup offered |
| miss_ready | output | 1 | Unit can accept a lookup |
| miss_addr | input | ADDR_W | Block address of the miss |
| res_valid | output | 1 | Lookup result available |
| res_ready | input | 1 | Result taken by the cache |
| res_hit | output | 1 | 1 = served from buffer, 0 = go to memory |
| res_data | output | DATA_W | Block data on a hit (0 on a miss) |
| mreq_valid | output | 1 | Prefetch request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | ADDR_W | Block address requested |
| mreq_tag | output | GEN_W | Stream generation of the request |
| mrsp_valid | input | 1 | Response presented (always accepted) |
| mrsp_tag | input | GEN_W | Tag echoed from the request |
| mrsp_data | input | DATA_W | Block data |

## Verification
The main function is driven with several lookup patterns. A cold miss shows the four-block fill. A front hit with data already present tests data return and the tail refill. A front hit with memory silent separates the stall path from the immediate path. A lookup equal to the second entry confirms that only the front counts. A second restart while the first stream's responses are still queued shows that stale tags are discarded, because a wrong design would return the older block's data. Holds on the request and result channels, and a stream that crosses the top of the address space, cover the boundary cases.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_WAIT, LK_RESP} lk_state_t;
endpackage

// File: rtl/ssb_store.sv
// Entry storage, request issue and response capture for one sequential stream.
module ssb_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int GEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              pop,
  output logic              active,
  output logic [ADDR_W-1:0] head_addr,
  output logic              head_ready,
  output logic [DATA_W-1:0] head_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [GEN_W-1:0]  mreq_tag,
  input  logic              mrsp_valid,
  input  logic [GEN_W-1:0]  mrsp_tag,
  input  logic [DATA_W-1:0] mrsp_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [GEN_W-1:0]  gen;
  logic [PTR_W-1:0]  head_ptr;
  logic [CNT_W-1:0]  n_iss;   // entries requested (includes received)
  logic [CNT_W-1:0]  n_rcv;   // entries with data, contiguous from the front
  logic              req_v;
  logic [ADDR_W-1:0] req_addr;
  logic [GEN_W-1:0]  req_tag;
  logic [DATA_W-1:0] ent_data [DEPTH];

  logic             fire_req, can_load, fire_rsp;
  logic [PTR_W-1:0] wr_idx;

  assign fire_req = req_v & mreq_ready;
  assign can_load = active & ~flush & (n_iss < CNT_W'(DEPTH)) & (~req_v | fire_req);
  assign fire_rsp = mrsp_valid & active & ~flush & (mrsp_tag == gen) & (n_rcv < n_iss);
  assign wr_idx   = head_ptr + PTR_W'(n_rcv);

  assign mreq_valid = req_v;
  assign mreq_addr  = req_addr;
  assign mreq_tag   = req_tag;
  assign head_ready = (n_rcv != '0);
  assign head_data  = ent_data[head_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      gen       <= '0;
      head_ptr  <= '0;
      head_addr <= '0;
      n_iss     <= '0;
      n_rcv     <= '0;
      req_v     <= 1'b0;
      req_addr  <= '0;
      req_tag   <= '0;
    end else begin
      if (fire_req) req_v <= 1'b0;
      if (can_load) begin
        req_v    <= 1'b1;
        req_addr <= head_addr + ADDR_W'(n_iss);
        req_tag  <= gen;
      end
      if (flush) begin
        active    <= 1'b1;
        gen       <= gen + GEN_W'(1);
        head_ptr  <= '0;
        head_addr <= flush_addr + ADDR_W'(1);
        n_iss     <= '0;
        n_rcv     <= '0;
      end else begin
        n_iss <= n_iss + CNT_W'(can_load) - CNT_W'(pop);
        n_rcv <= n_rcv + CNT_W'(fire_rsp) - CNT_W'(pop);
        if (pop) begin
          head_ptr  <= head_ptr + PTR_W'(1);
          head_addr <= head_addr + ADDR_W'(1);
        end
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (fire_rsp && wr_idx == PTR_W'(i)) ent_data[i] <= mrsp_data;
    end
  end

  // checker state: last request of the live stream
  logic              chk_v;
  logic [ADDR_W-1:0] chk_addr;
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      chk_v    <= 1'b0;
      chk_addr <= '0;
    end else if (fire_req && req_tag == gen) begin
      chk_v    <= 1'b1;
      chk_addr <= req_addr;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_v && !mreq_ready) |=> (req_v && $stable(req_addr) && $stable(req_tag))); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (n_rcv <= n_iss) && (n_iss <= CNT_W'(DEPTH))); // R11
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    pop |-> (n_rcv != '0)); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (fire_req && chk_v && req_tag == gen && !flush) |-> (req_addr == chk_addr + ADDR_W'(1))); // R2
endmodule

// File: rtl/ssb_lookup.sv
// Lookup sequencing: front compare, stall on pending front, result channel.
module ssb_lookup #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [DATA_W-1:0] res_data,
  input  logic              active,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              head_ready,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_addr
);
  import ssb_pkg::*;

  lk_state_t state;
  logic acc, match;

  assign miss_ready = (state == LK_IDLE);
  assign res_valid  = (state == LK_RESP);
  assign acc        = miss_valid & miss_ready;
  assign match      = active & (miss_addr == head_addr);
  assign pop        = (acc & match & head_ready) | ((state == LK_WAIT) & head_ready);
  assign flush      = acc & ~match;
  assign flush_addr = miss_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LK_IDLE;
      res_hit  <= 1'b0;
      res_data <= '0;
    end else begin
      unique case (state)
        LK_IDLE: if (acc) begin
          if (!match) begin
            res_hit  <= 1'b0;
            res_data <= '0;
            state    <= LK_RESP;
          end else if (head_ready) begin
            res_hit  <= 1'b1;
            res_data <= head_data;
            state    <= LK_RESP;
          end else begin
            state <= LK_WAIT;
          end
        end
        LK_WAIT: if (head_ready) begin
          res_hit  <= 1'b1;
          res_data <= head_data;
          state    <= LK_RESP;
        end
        LK_RESP: if (res_ready) state <= LK_IDLE;
        default: state <= LK_IDLE;
      endcase
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_data))); // R9
endmodule

// File: rtl/seq_stream_buf.sv
module seq_stream_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int GEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [DATA_W-1:0] res_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [GEN_W-1:0]  mreq_tag,
  input  logic              mrsp_valid,
  input  logic [GEN_W-1:0]  mrsp_tag,
  input  logic [DATA_W-1:0] mrsp_data
);
  logic              active, head_ready, pop, flush;
  logic [ADDR_W-1:0] head_addr, flush_addr;
  logic [DATA_W-1:0] head_data;

  ssb_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lookup (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_data(res_data),
    .active(active), .head_addr(head_addr), .head_ready(head_ready), .head_data(head_data),
    .pop(pop), .flush(flush), .flush_addr(flush_addr)
  );

  ssb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .GEN_W(GEN_W)) u_store (
    .clk(clk), .rst(rst),
    .flush(flush), .flush_addr(flush_addr), .pop(pop),
    .active(active), .head_addr(head_addr), .head_ready(head_ready), .head_data(head_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .mreq_tag(mreq_tag),
    .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data)
  );
endmodule

// File: tb/tb_seq_stream_buf.sv
`timescale 1ns/1ps
module tb_seq_stream_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0, miss_ready;
  logic [15:0] miss_addr = '0;
  logic        res_valid, res_ready = 1'b1, res_hit;
  logic [31:0] res_data;
  logic        mreq_valid, mreq_ready = 1'b1;
  logic [15:0] mreq_addr;
  logic [1:0]  mreq_tag;
  logic        mrsp_valid = 1'b0;
  logic [1:0]  mrsp_tag = '0;
  logic [31:0] mrsp_data = '0;

  int checks = 0, fails = 0;
  bit auto_rsp = 1'b1;
  logic [15:0] log_addr [256];
  logic [1:0]  log_tag  [256];
  int log_n = 0, rsp_i = 0;

  always #2.5 clk = ~clk;

  seq_stream_buf dut (.*);

  function automatic logic [31:0] blk(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: in-order responses, one per cycle, driven after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      mrsp_valid = 1'b0;
      if (auto_rsp && rsp_i < log_n) begin
        mrsp_valid = 1'b1;
        mrsp_tag   = log_tag[rsp_i];
        mrsp_data  = blk(log_addr[rsp_i]);
        rsp_i++;
      end
      if (mreq_valid && mreq_ready && log_n < 256) begin
        log_addr[log_n] = mreq_addr;
        log_tag[log_n]  = mreq_tag;
        log_n++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic lookup(input logic [15:0] a, output logic hit, output logic [31:0] data);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    hit  = res_hit;
    data = res_data;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1", "miss_ready", 64'(miss_ready), 64'd1);
    chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
    chk(mreq_valid == 1'b0, "R1", "mreq_valid", 64'(mreq_valid), 64'd0);
  endtask

  task automatic t_cold_and_hit;
    logic h; logic [31:0] d; int b;
    b = log_n;
    lookup(16'h0100, h, d);
    chk(h == 1'b0, "R2", "cold miss hit", 64'(h), 64'd0);
    idle(10);
    chk(log_n - b == 4, "R2", "request count", 64'(log_n - b), 64'd4);
    for (int k = 0; k < 4; k++)
      chk(log_addr[b+k] == 16'h0101 + 16'(k), "R2", "request addr", 64'(log_addr[b+k]), 64'(16'h0101 + 16'(k)));
    lookup(16'h0101, h, d);
    chk(h == 1'b1, "R3", "front hit", 64'(h), 64'd1);
    chk(d == blk(16'h0101), "R3", "hit data", 64'(d), 64'(blk(16'h0101)));
    idle(6);
    chk(log_n - b == 5, "R4", "refill count", 64'(log_n - b), 64'd5);
    chk(log_addr[b+4] == 16'h0105, "R4", "refill addr", 64'(log_addr[b+4]), 64'h0105);
  endtask

  task automatic t_pending;
    logic h; logic [31:0] d; int b;
    idle(4);
    auto_rsp = 1'b0;
    b = log_n;
    lookup(16'h0200, h, d);
    chk(h == 1'b0, "R2", "restart miss", 64'(h), 64'd0);
    idle(10);
    chk(log_n - b == 4, "R11", "outstanding cap", 64'(log_n - b), 64'd4);
    fork
      lookup(16'h0201, h, d);
      begin
        idle(6);
        chk(res_valid == 1'b0, "R5", "stall while pending", 64'(res_valid), 64'd0);
        auto_rsp = 1'b1;
      end
    join
    chk(h == 1'b1, "R5", "late hit", 64'(h), 64'd1);
    chk(d == blk(16'h0201), "R5", "late data", 64'(d), 64'(blk(16'h0201)));
  endtask

  task automatic t_deep_match;
    logic h; logic [31:0] d; int b;
    idle(10);
    b = log_n;
    lookup(16'h0203, h, d);
    chk(h == 1'b0, "R6", "second entry is a miss", 64'(h), 64'd0);
    idle(10);
    for (int k = 0; k < 4; k++)
      chk(log_addr[b+k] == 16'h0204 + 16'(k), "R6", "restart addr", 64'(log_addr[b+k]), 64'(16'h0204 + 16'(k)));
    lookup(16'h0204, h, d);
    chk(h == 1'b1 && d == blk(16'h0204), "R6", "new front hit data", 64'(d), 64'(blk(16'h0204)));
  endtask

  task automatic t_stale;
    logic h; logic [31:0] d; int b;
    idle(10);
    auto_rsp = 1'b0;
    b = log_n;
    lookup(16'h0300, h, d);
    idle(8);
    lookup(16'h0400, h, d);
    chk(h == 1'b0, "R7", "second restart miss", 64'(h), 64'd0);
    idle(8);
    chk(log_tag[b] != log_tag[b+4], "R7", "tags differ", 64'(log_tag[b+4]), 64'(~log_tag[b]));
    auto_rsp = 1'b1;
    lookup(16'h0401, h, d);
    chk(h == 1'b1, "R7", "hit after restart", 64'(h), 64'd1);
    chk(d == blk(16'h0401), "R7", "no stale data", 64'(d), 64'(blk(16'h0401)));
  endtask

  task automatic t_req_hold;
    logic h; logic [31:0] d;
    idle(12);
    mreq_ready = 1'b0;
    lookup(16'h0500, h, d);
    for (int k = 0; k < 4; k++) begin
      chk(mreq_valid == 1'b1, "R8", "held valid", 64'(mreq_valid), 64'd1);
      chk(mreq_addr == 16'h0501, "R8", "held addr", 64'(mreq_addr), 64'h0501);
      @(negedge clk);
    end
    mreq_ready = 1'b1;
  endtask

  task automatic t_res_hold;
    idle(12);
    res_ready  = 1'b0;
    miss_valid = 1'b1;
    miss_addr  = 16'h0501;
    @(negedge clk);
    miss_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(res_valid && res_hit, "R9", "held hit", 64'(res_hit), 64'd1);
      chk(res_data == blk(16'h0501), "R9", "held data", 64'(res_data), 64'(blk(16'h0501)));
      chk(miss_ready == 1'b0, "R9", "no accept while busy", 64'(miss_ready), 64'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", "result released", 64'(res_valid), 64'd0);
  endtask

  task automatic t_wrap;
    logic h; logic [31:0] d; int b;
    idle(10);
    b = log_n;
    lookup(16'hFFFE, h, d);
    idle(10);
    chk(log_addr[b] == 16'hFFFF, "R10", "top block", 64'(log_addr[b]), 64'hFFFF);
    chk(log_addr[b+1] == 16'h0000, "R10", "wrapped block", 64'(log_addr[b+1]), 64'h0);
    lookup(16'hFFFF, h, d);
    chk(h == 1'b1 && d == blk(16'hFFFF), "R10", "hit at top", 64'(d), 64'(blk(16'hFFFF)));
    lookup(16'h0000, h, d);
    chk(h == 1'b1 && d == blk(16'h0000), "R10", "hit after wrap", 64'(d), 64'(blk(16'h0000)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cold_and_hit();
    t_pending();
    t_deep_match();
    t_stale();
    t_req_hold();
    t_res_hold();
    t_wrap();
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule